// File: doc/BRIEF.md
# RGMII Receive Retiming Sampler

This block samples the four receive data bits and the receive control bit of an RGMII link using a separate, faster timing-adjustment clock rather than the receive clock itself. The receive clock pin is brought into the fast domain through a synchronizer, and both of its edges are detected there. Each detected edge restarts a phase counter. Each of the five receive lanes is captured once the counter reaches a programmable sample point. A per-lane skew mask can push chosen lanes later by a fixed number of fast cycles, to make up for a pin that arrives late.

One nibble and one control bit are produced per receive-clock half-cycle, tagged as a rising or falling half. A pair, rising then falling, forms one byte, with the low nibble on the rising half. An alignment option holds back the strobe until a complete rising/falling pair has been sampled, so that the downstream logic sees whole bytes. A bypass mode skips the counter and captures the pins as soon as the edge is seen. If retiming is requested while the timing-adjustment clock is reported as not running, this is a configuration error and no samples are issued. If a half-cycle ends before all of its lanes have been captured, that half is dropped and a sticky late flag is raised.

Top module: `rgmii_rx_retimer`

## Requirements
- R1: While reset is held, and directly after it, o_strobe, o_fall, o_late, o_rise_data, o_rise_ctl, o_fall_data and o_fall_ctl are all 0.
- R2: With cfg_retime_en = 0, a toggle of rx_clk_pin that is applied between rising edges of clk produces a one-cycle o_strobe after the 3rd following rising edge of clk. The pins are captured at that same edge, and cfg_delay and cfg_skew have no effect.
- R3: With retiming active, every rising and every falling transition of rx_clk_pin restarts the phase counter. The counter reads 0 in the cycle that follows the 3rd clk edge after the toggle, and then increments by 1 per clk cycle, saturating at its maximum value.
- R4: A lane whose skew bit is clear is sampled at the (4 + cfg_delay)th clk rising edge after the rx_clk_pin toggle. A pin change applied m cycles after the toggle is captured if m <= 3 + cfg_delay, and missed otherwise.
- R5: Each set bit of cfg_skew moves the sample point of its lane later by SKEW_TICKS (default 5) clk cycles. The bit mapping is: bit 0 is the control lane, bit 1 is data[3], bit 2 is data[2], bit 3 is data[1] and bit 4 is data[0].
- R6: In retime mode without alignment, o_strobe pulses for one cycle after the (5 + latest lane sample point)th clk edge after the toggle. o_fall = 1 marks a half that began with a falling rx_clk_pin. Its nibble goes to o_fall_data/o_fall_ctl; otherwise it goes to o_rise_data/o_rise_ctl.
- R7: If the next rx_clk_pin transition is detected before every lane of the current half has been sampled, that half gives no strobe, and o_late becomes 1 and stays 1 until reset.
- R8: With cfg_align = 1, a completed rising half gives no strobe. The following completed falling half gives one strobe with o_fall = 1, and both nibbles of the byte are then valid.
- R9: o_cfg_err = cfg_retime_en AND NOT adj_clk_ok, with no delay. While it is 1, no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing-adjustment (oversampling) clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| adj_clk_ok | input | 1 | Indicates that the timing-adjustment clock is running |
| cfg_retime_en | input | 1 | 1 selects counter-timed sampling, 0 selects bypass |
| cfg_align | input | 1 | 1 issues strobes only for complete rising/falling pairs |
| cfg_delay | input | DLY_W (5) | Counter value at which unskewed lanes are sampled |
| cfg_skew | input | 5 | Per-lane late-sample mask (lane mapping in R5) |
| rx_clk_pin | input | 1 | RGMII receive clock pin |
| rx_ctl_pin | input | 1 | RGMII receive control pin |
| rx_data_pin | input | 4 | RGMII receive data pins |
| o_strobe | output | 1 | One-cycle pulse: a new sample is valid |
| o_fall | output | 1 | Tag of the latest half: 1 = falling half |
| o_rise_data | output | 4 | Nibble of the latest rising half (low nibble of the byte) |
| o_rise_ctl | output | 1 | Control bit of the latest rising half |
| o_fall_data | output | 4 | Nibble of the latest falling half (high nibble of the byte) |
| o_fall_ctl | output | 1 | Control bit of the latest falling half |
| o_late | output | 1 | Sticky flag: a half ended before all of its lanes were sampled |
| o_cfg_err | output | 1 | Retiming requested without a running timing-adjustment clock |

## Verification
All latencies are counted from the clk rising edge that follows an rx_clk_pin toggle. In bypass, the strobe is due 3 edges later. In retime mode, a lane is sampled at edge 4 plus its target, and the strobe follows at edge 5 plus the largest target. The late flag rises at the edge after the second synchronized transition, which is edge 3 after that toggle. The bench drives every input on the falling clk edge and records the cycle number of each strobe shortly after the rising edge. Each check then compares that cycle number with the exact expected index, and it places pin changes at offsets 3 + target and 4 + target to probe both sides of each sample point.

// File: rtl/rgrt_pkg.sv
package rgrt_pkg;

  // Five receive lanes: control plus four data bits.
  localparam int LANES = 5;

  typedef struct packed {
    logic       ctl;
    logic [3:0] data;
  } nib_t;

  // Lane order: 0 = control, 1 = data[3], 2 = data[2], 3 = data[1], 4 = data[0].
  function automatic logic [LANES-1:0] pack_lanes(input logic ctl, input logic [3:0] d);
    return {d[0], d[1], d[2], d[3], ctl};
  endfunction

  function automatic nib_t unpack_lanes(input logic [LANES-1:0] v);
    nib_t n;
    n.ctl  = v[0];
    n.data = {v[1], v[2], v[3], v[4]};
    return n;
  endfunction

  // Counter value at which a lane is captured.
  function automatic int unsigned lane_target(input int unsigned dly,
                                              input logic        skew_bit,
                                              input int unsigned ticks);
    return skew_bit ? dly + ticks : dly;
  endfunction

endpackage

// File: rtl/rgrt_edge_sync.sv
module rgrt_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_clk_pin,
  output logic o_level,
  output logic o_edge
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SH_W-2:0], rx_clk_pin};
  end

  assign o_level = sh[SYNC_STAGES-1];
  assign o_edge  = sh[SYNC_STAGES-1] ^ sh[SYNC_STAGES];
endmodule

// File: rtl/rgrt_phase_cnt.sv
module rgrt_phase_cnt #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             i_restart,
  output logic [CNT_W-1:0] o_cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)              o_cnt <= '1;
    else if (i_restart)      o_cnt <= '0;
    else if (o_cnt != '1)    o_cnt <= o_cnt + 1'b1;
  end
endmodule

// File: rtl/rgrt_lane_capture.sv
module rgrt_lane_capture #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             i_clear,
  input  logic             i_arm,
  input  logic [CNT_W-1:0] i_cnt,
  input  logic [CNT_W-1:0] i_target,
  input  logic             i_pin,
  output logic             o_val,
  output logic             o_got
);
  logic hit;
  assign hit = i_arm && !o_got && (i_cnt == i_target);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_val <= 1'b0;
      o_got <= 1'b0;
    end else if (i_clear) begin
      o_got <= 1'b0;
    end else if (hit) begin
      o_val <= i_pin;
      o_got <= 1'b1;
    end
  end
endmodule

// File: rtl/rgmii_rx_retimer.sv
module rgmii_rx_retimer
  import rgrt_pkg::*;
#(
  parameter int DLY_W       = 5,
  parameter int SKEW_TICKS  = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adj_clk_ok,
  input  logic             cfg_retime_en,
  input  logic             cfg_align,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic [LANES-1:0] cfg_skew,
  input  logic             rx_clk_pin,
  input  logic             rx_ctl_pin,
  input  logic [3:0]       rx_data_pin,
  output logic             o_strobe,
  output logic             o_fall,
  output logic [3:0]       o_rise_data,
  output logic             o_rise_ctl,
  output logic [3:0]       o_fall_data,
  output logic             o_fall_ctl,
  output logic             o_late,
  output logic             o_cfg_err
);
  localparam int DLY_MAX = (1 << DLY_W) - 1;
  localparam int CNT_W   = $clog2(DLY_MAX + SKEW_TICKS + 2);

  // Named internal events, visible to the bound checker.
  logic             rx_level;
  logic             edge_evt;
  logic [CNT_W-1:0] cnt;
  logic [LANES-1:0] lane_pin, lane_val, lane_got;
  logic             all_got, retime_ok, edge_ok;
  logic             byp_emit, half_done, late_evt, emit, emit_pol;
  logic [LANES-1:0] emit_lanes;
  nib_t             emit_nib;
  logic             active, half_rise, rise_pend;

  rgrt_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_clk_pin(rx_clk_pin),
    .o_level   (rx_level),
    .o_edge    (edge_evt)
  );

  rgrt_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .i_restart(edge_evt),
    .o_cnt    (cnt)
  );

  assign lane_pin = pack_lanes(rx_ctl_pin, rx_data_pin);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [CNT_W-1:0] tgt;
    assign tgt = CNT_W'(lane_target(int'(cfg_delay), cfg_skew[g], SKEW_TICKS));

    rgrt_lane_capture #(.CNT_W(CNT_W)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .i_clear (edge_evt),
      .i_arm   (active),
      .i_cnt   (cnt),
      .i_target(tgt),
      .i_pin   (lane_pin[g]),
      .o_val   (lane_val[g]),
      .o_got   (lane_got[g])
    );
  end

  assign o_cfg_err  = cfg_retime_en & ~adj_clk_ok;
  assign retime_ok  = cfg_retime_en & adj_clk_ok;
  assign edge_ok    = edge_evt & ~o_cfg_err;
  assign all_got    = &lane_got;
  assign byp_emit   = edge_ok & ~cfg_retime_en;
  assign half_done  = active & all_got & retime_ok;
  assign late_evt   = edge_ok & active & ~all_got;
  assign emit       = byp_emit | half_done;
  assign emit_pol   = byp_emit ? rx_level : half_rise;
  assign emit_lanes = byp_emit ? lane_pin : lane_val;
  assign emit_nib   = unpack_lanes(emit_lanes);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_strobe    <= 1'b0;
      o_fall      <= 1'b0;
      o_rise_data <= '0;
      o_rise_ctl  <= 1'b0;
      o_fall_data <= '0;
      o_fall_ctl  <= 1'b0;
      o_late      <= 1'b0;
      active      <= 1'b0;
      half_rise   <= 1'b0;
      rise_pend   <= 1'b0;
    end else begin
      o_strobe <= 1'b0;
      if (emit) begin
        o_fall <= ~emit_pol;
        if (emit_pol) begin
          o_rise_data <= emit_nib.data;
          o_rise_ctl  <= emit_nib.ctl;
          rise_pend   <= 1'b1;
          o_strobe    <= ~cfg_align;
        end else begin
          o_fall_data <= emit_nib.data;
          o_fall_ctl  <= emit_nib.ctl;
          rise_pend   <= 1'b0;
          o_strobe    <= ~cfg_align | rise_pend;
        end
      end
      if (half_done || o_cfg_err) active <= 1'b0;
      if (late_evt) begin
        o_late    <= 1'b1;
        rise_pend <= 1'b0;
      end
      if (edge_ok) begin
        half_rise <= rx_level;
        active    <= retime_ok;
      end
    end
  end
endmodule

// File: rtl/rgrt_checker.sv
module rgrt_checker #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_align,
  input logic             cfg_retime_en,
  input logic             o_cfg_err,
  input logic             o_strobe,
  input logic             o_fall,
  input logic             o_late,
  input logic             edge_evt,
  input logic             half_done,
  input logic [CNT_W-1:0] cnt
);
  // R2
  a_r2_bypass_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt && !cfg_retime_en) |=> o_strobe);

  // R3
  a_r3_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> (cnt == '0));

  // R6
  a_r6_done_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (half_done && !cfg_align) |=> o_strobe);

  // R7
  a_r7_late_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    o_late |=> o_late);

  // R8
  a_r8_align_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_align |=> (!o_strobe || o_fall));

  // R9
  a_r9_err_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    o_cfg_err |=> !o_strobe);
endmodule

bind rgmii_rx_retimer rgrt_checker #(.CNT_W(CNT_W)) u_rgrt_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_align    (cfg_align),
  .cfg_retime_en(cfg_retime_en),
  .o_cfg_err    (o_cfg_err),
  .o_strobe     (o_strobe),
  .o_fall       (o_fall),
  .o_late       (o_late),
  .edge_evt     (edge_evt),
  .half_done    (half_done),
  .cnt          (cnt)
);

// File: tb/rgmii_rx_retimer_bench.sv
`timescale 1ns/1ps
module rgmii_rx_retimer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       adj_clk_ok = 1'b1;
  logic       cfg_retime_en = 1'b1;
  logic       cfg_align = 1'b0;
  logic [4:0] cfg_delay = '0;
  logic [4:0] cfg_skew = '0;
  logic       rx_clk_pin = 1'b0;
  logic       rx_ctl_pin = 1'b0;
  logic [3:0] rx_data_pin = '0;
  logic       o_strobe, o_fall, o_rise_ctl, o_fall_ctl, o_late, o_cfg_err;
  logic [3:0] o_rise_data, o_fall_data;

  localparam int SKEW = 5;

  rgmii_rx_retimer u_rgmii_rx_retimer (
    .clk(clk), .rst_n(rst_n), .adj_clk_ok(adj_clk_ok),
    .cfg_retime_en(cfg_retime_en), .cfg_align(cfg_align),
    .cfg_delay(cfg_delay), .cfg_skew(cfg_skew),
    .rx_clk_pin(rx_clk_pin), .rx_ctl_pin(rx_ctl_pin), .rx_data_pin(rx_data_pin),
    .o_strobe(o_strobe), .o_fall(o_fall),
    .o_rise_data(o_rise_data), .o_rise_ctl(o_rise_ctl),
    .o_fall_data(o_fall_data), .o_fall_ctl(o_fall_ctl),
    .o_late(o_late), .o_cfg_err(o_cfg_err)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int stb_cnt = 0;
  int stb_cyc = -1;
  bit finished = 1'b0;

  // Strobe monitor: sampled 1 ns after each rising edge.
  always @(posedge clk) begin
    cyc++;
    #1;
    if (o_strobe) begin
      stb_cnt++;
      stb_cyc = cyc;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic toggle(input logic lvl, input logic [3:0] d, input logic c, output int n);
    rx_clk_pin  = lvl;
    rx_data_pin = d;
    rx_ctl_pin  = c;
    n = cyc;
  endtask

  task automatic t_reset;
    check("R1 strobe", o_strobe, 0);
    check("R1 late", o_late, 0);
    check("R1 rise_data", o_rise_data, 0);
    check("R1 fall_data", o_fall_data, 0);
    check("R1 ctl", {o_rise_ctl, o_fall_ctl, o_fall}, 0);
    wait_cyc(2);
    rst_n = 1'b1;
    wait_cyc(4);
    check("R1 after release", {o_strobe, o_late, o_fall}, 0);
  endtask

  task automatic t_basic;
    int n, s0;
    cfg_retime_en = 1; cfg_delay = 2; cfg_skew = 0; cfg_align = 0;
    s0 = stb_cnt;
    toggle(1, 4'h5, 1, n); wait_cyc(16);
    check("R6 rise strobe cycle", stb_cyc, n + 7);
    check("R6 rise strobe count", stb_cnt, s0 + 1);
    check("R6 rise tag", o_fall, 0);
    check("R6 rise data", o_rise_data, 5);
    check("R6 rise ctl", o_rise_ctl, 1);
    toggle(0, 4'hA, 0, n); wait_cyc(16);
    check("R3 fall strobe cycle", stb_cyc, n + 7);
    check("R6 fall tag", o_fall, 1);
    check("R6 fall data", o_fall_data, 10);
    check("R6 fall ctl", o_fall_ctl, 0);
  endtask

  task automatic t_delay;
    int n;
    cfg_delay = 4; cfg_skew = 0;
    toggle(1, 4'h3, 0, n); wait_cyc(7);
    rx_data_pin = 4'hC; rx_ctl_pin = 1; wait_cyc(12);
    check("R4 change at 3+delay caught", o_rise_data, 12);
    check("R4 ctl caught", o_rise_ctl, 1);
    check("R4 strobe cycle", stb_cyc, n + 9);
    toggle(0, 4'h3, 0, n); wait_cyc(8);
    rx_data_pin = 4'hC; rx_ctl_pin = 1; wait_cyc(12);
    check("R4 change at 4+delay missed", o_fall_data, 3);
    check("R4 ctl missed", o_fall_ctl, 0);
  endtask

  task automatic t_skew;
    int n;
    cfg_delay = 1; cfg_skew = 5'b00011;
    toggle(1, 4'h0, 0, n); wait_cyc(6);
    rx_data_pin = 4'hF; rx_ctl_pin = 1; wait_cyc(14);
    check("R5 skew ctl and data3", o_rise_data, 8);
    check("R5 skew bit0 ctl", o_rise_ctl, 1);
    check("R5 skew strobe cycle", stb_cyc, n + 1 + SKEW + 5);
    cfg_skew = 5'b10000;
    toggle(0, 4'h0, 0, n); wait_cyc(6);
    rx_data_pin = 4'hF; rx_ctl_pin = 1; wait_cyc(14);
    check("R5 skew bit4 data0", o_fall_data, 1);
    check("R5 unskewed ctl", o_fall_ctl, 0);
    cfg_skew = 0;
  endtask

  task automatic t_align;
    int n, s0;
    cfg_delay = 1; cfg_align = 1;
    s0 = stb_cnt;
    toggle(1, 4'h6, 0, n); wait_cyc(12);
    check("R8 no strobe on rising half", stb_cnt, s0);
    toggle(0, 4'h9, 1, n); wait_cyc(12);
    check("R8 one strobe per pair", stb_cnt, s0 + 1);
    check("R8 pair strobe cycle", stb_cyc, n + 6);
    check("R8 tag", o_fall, 1);
    check("R8 low nibble", o_rise_data, 6);
    check("R8 high nibble", o_fall_data, 9);
    check("R8 fall ctl", o_fall_ctl, 1);
    cfg_align = 0;
  endtask

  task automatic t_bypass;
    int n;
    cfg_retime_en = 0; cfg_delay = 20; cfg_skew = 5'b11111;
    wait_cyc(2);
    toggle(1, 4'h7, 1, n); wait_cyc(10);
    check("R2 bypass strobe cycle", stb_cyc, n + 3);
    check("R2 bypass rise data", o_rise_data, 7);
    check("R2 bypass rise ctl", o_rise_ctl, 1);
    toggle(0, 4'h2, 0, n); wait_cyc(10);
    check("R2 bypass fall cycle", stb_cyc, n + 3);
    check("R2 bypass fall data", o_fall_data, 2);
    cfg_skew = 0;
  endtask

  task automatic t_cfg_err;
    int n, s0;
    cfg_retime_en = 1; cfg_delay = 1; adj_clk_ok = 0;
    wait_cyc(1);
    check("R9 error flag", o_cfg_err, 1);
    s0 = stb_cnt;
    toggle(1, 4'h4, 0, n); wait_cyc(20);
    toggle(0, 4'h4, 0, n); wait_cyc(20);
    check("R9 no strobe under error", stb_cnt, s0);
    adj_clk_ok = 1;
    wait_cyc(1);
    check("R9 error clears", o_cfg_err, 0);
    wait_cyc(10);
  endtask

  task automatic t_late;
    int n, s0;
    cfg_retime_en = 1; cfg_delay = 20;
    s0 = stb_cnt;
    toggle(1, 4'h1, 0, n); wait_cyc(10);
    toggle(0, 4'h1, 0, n); wait_cyc(2);
    check("R7 late not yet", o_late, 0);
    wait_cyc(1);
    check("R7 late raised", o_late, 1);
    check("R7 short half dropped", stb_cnt, s0);
    wait_cyc(40);
    check("R7 late sticky", o_late, 1);
  endtask

  initial begin
    wait_cyc(1);
    t_reset();
    t_basic();
    t_delay();
    t_skew();
    t_align();
    t_bypass();
    t_cfg_err();
    t_late();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule